// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block is the front end of a Reed-Solomon decoder over GF(256) with 8-bit symbols. It takes a byte-wide received stream and computes the syndromes for each complete codeword. The stream is qualified by a valid strobe and framed by a first-symbol marker. The codeword length and the number of check symbols are inputs that the block samples at each frame start, so one instance serves any supported code without rebuilding.

While the syndromes build up, the block also records where the symbols that an upstream inner decoder flagged as erased sit in the codeword. When the last symbol of a codeword arrives, the syndrome set, the erasure location list, its count and an overflow flag are all presented together with a one-cycle done strobe. They stay steady until the next codeword completes, so a key-equation stage can pick them up at its own pace.

A build-time parameter picks one of two arithmetic conventions. The first uses field polynomial x^8+x^4+x^3+x^2+1 with generator roots starting at alpha^0. The second uses x^8+x^7+x^2+x+1 with roots starting at alpha^120.

Top module: `rs_syndrome_calc`

## Requirements
- R1: Symbols are 8 bits. The codeword length N (50..255) and check count C (0..20) are sampled from `cfg_len_i` and `cfg_chk_i` on the frame-start symbol. Changing them in the middle of a codeword has no effect on that codeword.
- R2: With `CONV_B`=0, slot j of `synd_o` (bits 8j+7..8j) equals r(alpha^j) for j < C, using field polynomial 0x11D and alpha = 0x02.
- R3: With `CONV_B`=1, slot j equals r(alpha^(120+j)) for j < C, using field polynomial 0x187 and alpha = 0x02.
- R4: The first received symbol is the coefficient of x^(N-1). `done_o` pulses high for exactly one cycle, in the cycle after the N-th valid symbol is accepted. All result outputs update in that cycle and then hold until the next done.
- R5: Exactly C syndromes are produced. Slots j >= C read zero.
- R6: While `sym_valid_i` is low, `sym_i`, `frame_start_i` and `erased_i` have no effect. Valid symbols that arrive outside a frame (before any frame start, or after a codeword has completed) are also ignored.
- R7: A frame start that arrives before N symbols of the current codeword have been counted discards the partial codeword and starts a new one. No done is ever produced for the discarded codeword.
- R8: An erased symbol at index i (0 = first) is reported as alpha^(N-1-i) in the field of the selected convention. Locations fill slots of `era_loc_o` in arrival order from slot 0, `era_cnt_o` gives how many slots are filled, and slots at or above the count read zero.
- R9: At most C locations are stored. If more than C erasures arrive, the first C are kept, `era_cnt_o` equals C and `era_ovf_o` is high.
- R10: A codeword from a valid systematic encoder that has no errors gives all-zero syndromes.
- R11: After reset, `done_o`, all syndromes, all locations, the count and the overflow flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len_i | input | 8 | Codeword length N, sampled at frame start |
| cfg_chk_i | input | CHK_W (5) | Check-symbol count C, sampled at frame start |
| sym_i | input | 8 | Received symbol |
| sym_valid_i | input | 1 | Qualifies sym_i, frame_start_i and erased_i |
| frame_start_i | input | 1 | Marks the first symbol of a codeword |
| erased_i | input | 1 | Marks the current symbol as an erasure |
| done_o | output | 1 | One-cycle strobe: results are ready |
| synd_o | output | MAX_CHK*8 (160) | Syndromes, slot j at bits 8j+7..8j |
| era_loc_o | output | MAX_CHK*8 (160) | Erasure locations, slot k at bits 8k+7..8k |
| era_cnt_o | output | CHK_W (5) | Number of stored erasure locations |
| era_ovf_o | output | 1 | More erasures arrived than could be stored |

## Verification
Several properties are checked on every cycle: done is a single-cycle pulse that follows an accepted symbol, the results stay steady between done strobes, syndrome slots at or above the check count are zero, the erasure list is zero above its count, and overflow only ever appears together with a full list. The actual syndrome values cannot be checked by a cycle property. The scenarios show them for both conventions against a power-sum evaluation: error-free encoded words, corrupted words, configuration changes in the middle of a frame, aborted frames, idle cycles carrying junk, and back-to-back short codewords.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
  localparam int SYM_W = 8;
  localparam int LEN_W = 8;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [8:0] poly);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? poly[7:0] : 8'h00);
    end
    return p;
  endfunction

  // square-and-multiply, exponent up to 511
  function automatic logic [7:0] gf_pow(input logic [7:0] a, input logic [8:0] e,
                                        input logic [8:0] poly);
    logic [7:0] r;
    logic [7:0] s;
    r = 8'h01;
    s = a;
    for (int i = 0; i < 9; i++) begin
      if (e[i]) r = gf_mul(r, s, poly);
      s = gf_mul(s, s, poly);
    end
    return r;
  endfunction

  function automatic logic [8:0] field_poly(input bit conv_b);
    return conv_b ? 9'h187 : 9'h11D;
  endfunction

  function automatic int first_root(input bit conv_b);
    return conv_b ? 120 : 0;
  endfunction
endpackage

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl #(
  parameter int MAX_CHK = 20,
  parameter int CHK_W   = 5,
  parameter int LEN_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             frame_start_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [CHK_W-1:0] cfg_chk_i,
  output logic             start_o,
  output logic             step_o,
  output logic             last_o,
  output logic [LEN_W-1:0] len_eff_o,
  output logic [CHK_W-1:0] chk_eff_o,
  output logic [CHK_W-1:0] chk_q_o
);
  logic             active_q;
  logic [LEN_W-1:0] idx_q, len_q;
  logic [CHK_W-1:0] chk_q, chk_in;

  assign chk_in    = (cfg_chk_i > CHK_W'(MAX_CHK)) ? CHK_W'(MAX_CHK) : cfg_chk_i;
  assign start_o   = valid_i & frame_start_i;
  assign step_o    = valid_i & ~frame_start_i & active_q;
  assign last_o    = step_o & (idx_q == len_q - 1'b1);
  assign len_eff_o = start_o ? cfg_len_i : len_q;
  assign chk_eff_o = start_o ? chk_in : chk_q;
  assign chk_q_o   = chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
      chk_q    <= '0;
    end else if (start_o) begin
      active_q <= 1'b1;
      idx_q    <= LEN_W'(1);
      len_q    <= cfg_len_i;
      chk_q    <= chk_in;
    end else if (step_o) begin
      idx_q <= idx_q + 1'b1;
      if (last_o) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell #(
  parameter logic [7:0] ROOT = 8'h01,
  parameter logic [8:0] POLY = 9'h11D
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       step_i,
  input  logic [7:0] sym_i,
  output logic [7:0] acc_d_o
);
  logic [7:0] acc_q;

  // Horner step: acc * root + symbol
  always_comb begin
    if (start_i)     acc_d_o = sym_i;
    else if (step_i) acc_d_o = rs_syn_pkg::gf_mul(acc_q, ROOT, POLY) ^ sym_i;
    else             acc_d_o = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d_o;
  end
endmodule

// File: rtl/rs_syn_era.sv
module rs_syn_era #(
  parameter int         MAX_CHK = 20,
  parameter int         CHK_W   = 5,
  parameter logic [8:0] POLY    = 9'h11D
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   step_i,
  input  logic                   erased_i,
  input  logic [7:0]             len_i,
  input  logic [CHK_W-1:0]       chk_i,
  output logic [MAX_CHK*8-1:0]   list_d_o,
  output logic [CHK_W-1:0]       cnt_d_o,
  output logic                   ovf_d_o
);
  localparam logic [7:0] A_INV = rs_syn_pkg::gf_pow(8'h02, 9'd254, POLY);

  logic [7:0]           pos_q, first_pow, loc;
  logic [MAX_CHK*8-1:0] list_q;
  logic [CHK_W-1:0]     cnt_q, base;
  logic                 ovf_q, accept, wr;

  assign first_pow = rs_syn_pkg::gf_pow(8'h02, {1'b0, len_i} - 9'd1, POLY);
  assign loc       = start_i ? first_pow : pos_q;
  assign accept    = start_i | step_i;
  assign base      = start_i ? '0 : cnt_q;
  assign wr        = accept & erased_i & (base < chk_i);
  assign cnt_d_o   = base + CHK_W'(wr);
  assign ovf_d_o   = start_i ? (erased_i & (chk_i == '0))
                             : (ovf_q | (step_i & erased_i & (cnt_q >= chk_i)));

  for (genvar k = 0; k < MAX_CHK; k++) begin : g_slot
    assign list_d_o[k*8 +: 8] = (wr && base == CHK_W'(k)) ? loc :
                                start_i ? 8'h00 : list_q[k*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      list_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (accept) pos_q <= rs_syn_pkg::gf_mul(loc, A_INV, POLY);
      list_q <= list_d_o;
      cnt_q  <= cnt_d_o;
      ovf_q  <= ovf_d_o;
    end
  end
endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc #(
  parameter int  MAX_CHK = 20,
  parameter bit  CONV_B  = 1'b0,
  localparam int CHK_W   = $clog2(MAX_CHK + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           cfg_len_i,
  input  logic [CHK_W-1:0]     cfg_chk_i,
  input  logic [7:0]           sym_i,
  input  logic                 sym_valid_i,
  input  logic                 frame_start_i,
  input  logic                 erased_i,
  output logic                 done_o,
  output logic [MAX_CHK*8-1:0] synd_o,
  output logic [MAX_CHK*8-1:0] era_loc_o,
  output logic [CHK_W-1:0]     era_cnt_o,
  output logic                 era_ovf_o
);
  localparam logic [8:0] POLY = rs_syn_pkg::field_poly(CONV_B);
  localparam int         B0   = rs_syn_pkg::first_root(CONV_B);

  logic                 start, step, last;
  logic [7:0]           len_eff;
  logic [CHK_W-1:0]     chk_eff, chk_cur, cnt_d;
  logic [MAX_CHK*8-1:0] acc_d, synd_mask, list_d;
  logic                 ovf_d;

  rs_syn_ctrl #(.MAX_CHK(MAX_CHK), .CHK_W(CHK_W), .LEN_W(rs_syn_pkg::LEN_W)) i_ctrl (
    .clk_i, .rst_ni,
    .valid_i(sym_valid_i), .frame_start_i,
    .cfg_len_i, .cfg_chk_i,
    .start_o(start), .step_o(step), .last_o(last),
    .len_eff_o(len_eff), .chk_eff_o(chk_eff), .chk_q_o(chk_cur)
  );

  for (genvar j = 0; j < MAX_CHK; j++) begin : g_cell
    localparam logic [7:0] ROOT = rs_syn_pkg::gf_pow(8'h02, 9'(B0 + j), POLY);
    rs_syn_cell #(.ROOT(ROOT), .POLY(POLY)) i_cell (
      .clk_i, .rst_ni,
      .start_i(start), .step_i(step), .sym_i,
      .acc_d_o(acc_d[j*8 +: 8])
    );
    assign synd_mask[j*8 +: 8] = (CHK_W'(j) < chk_eff) ? acc_d[j*8 +: 8] : 8'h00;
  end

  rs_syn_era #(.MAX_CHK(MAX_CHK), .CHK_W(CHK_W), .POLY(POLY)) i_era (
    .clk_i, .rst_ni,
    .start_i(start), .step_i(step), .erased_i,
    .len_i(len_eff), .chk_i(chk_eff),
    .list_d_o(list_d), .cnt_d_o(cnt_d), .ovf_d_o(ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      synd_o    <= '0;
      era_loc_o <= '0;
      era_cnt_o <= '0;
      era_ovf_o <= 1'b0;
    end else begin
      done_o <= last;
      if (last) begin
        synd_o    <= synd_mask;
        era_loc_o <= list_d;
        era_cnt_o <= cnt_d;
        era_ovf_o <= ovf_d;
      end
    end
  end
endmodule

// File: rtl/rs_syndrome_calc_chk.sv
module rs_syndrome_calc_chk #(
  parameter int MAX_CHK = 20,
  parameter int CHK_W   = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sym_valid_i,
  input logic                 done_o,
  input logic [MAX_CHK*8-1:0] synd_o,
  input logic [MAX_CHK*8-1:0] era_loc_o,
  input logic [CHK_W-1:0]     era_cnt_o,
  input logic                 era_ovf_o,
  input logic [CHK_W-1:0]     chk_cur
);
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_symbol_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(sym_valid_i));

  assert_results_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(synd_o) && $stable(era_loc_o) && $stable(era_cnt_o) && $stable(era_ovf_o)));

  assert_era_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> era_cnt_o <= chk_cur);

  assert_ovf_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && era_ovf_o) |-> era_cnt_o == chk_cur);

  for (genvar j = 0; j < MAX_CHK; j++) begin : g_slot
    assert_unused_synd_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && CHK_W'(j) >= chk_cur) |-> synd_o[j*8 +: 8] == 8'h00);
    assert_era_tail_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (CHK_W'(j) >= era_cnt_o) |-> era_loc_o[j*8 +: 8] == 8'h00);
  end
endmodule

bind rs_syndrome_calc rs_syndrome_calc_chk #(.MAX_CHK(MAX_CHK), .CHK_W(CHK_W)) i_chk (
  .clk_i, .rst_ni, .sym_valid_i, .done_o, .synd_o,
  .era_loc_o, .era_cnt_o, .era_ovf_o, .chk_cur(chk_cur)
);

// File: tb/test_rs_syndrome_calc.sv
module test_rs_syndrome_calc;
  localparam int MAX_CHK = 20;
  localparam int CHK_W   = 5;
  localparam int W       = MAX_CHK * 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]       cfg_len = 8'd255;
  logic [CHK_W-1:0] cfg_chk = 5'd16;
  logic [7:0]       sym = 8'h00;
  logic             vld = 1'b0, fs = 1'b0, era = 1'b0;

  logic             done_a, done_b, ovf_a, ovf_b;
  logic [W-1:0]     synd_a, synd_b, loc_a, loc_b;
  logic [CHK_W-1:0] cnt_a, cnt_b;

  rs_syndrome_calc #(.MAX_CHK(MAX_CHK), .CONV_B(1'b0)) i_rs_syndrome_calc (
    .clk_i(clk), .rst_ni, .cfg_len_i(cfg_len), .cfg_chk_i(cfg_chk), .sym_i(sym),
    .sym_valid_i(vld), .frame_start_i(fs), .erased_i(era),
    .done_o(done_a), .synd_o(synd_a), .era_loc_o(loc_a), .era_cnt_o(cnt_a), .era_ovf_o(ovf_a));

  rs_syndrome_calc #(.MAX_CHK(MAX_CHK), .CONV_B(1'b1)) i_rs_syndrome_calc_b (
    .clk_i(clk), .rst_ni, .cfg_len_i(cfg_len), .cfg_chk_i(cfg_chk), .sym_i(sym),
    .sym_valid_i(vld), .frame_start_i(fs), .erased_i(era),
    .done_o(done_b), .synd_o(synd_b), .era_loc_o(loc_b), .era_cnt_o(cnt_b), .era_ovf_o(ovf_b));

  int    vectors = 0, miscompares = 0, cycles = 0;
  string req = "R11";
  bit    finished = 0;

  logic [7:0] exp_t [0:1][0:254];
  int         log_t [0:1][0:255];

  function automatic logic [7:0] bm(int c, logic [7:0] a, logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return exp_t[c][(log_t[c][a] + log_t[c][b]) % 255];
  endfunction

  // reference model state
  bit         m_act = 0;
  int         m_len = 0, m_chk = 0;
  logic [7:0] m_syms[$];
  int         m_eras[$];
  bit         e_done = 0;
  logic [W-1:0]     e_synd [0:1];
  logic [W-1:0]     e_loc  [0:1];
  logic [CHK_W-1:0] e_cnt = '0;
  bit               e_ovf = 0;

  initial begin
    e_synd[0] = '0; e_synd[1] = '0; e_loc[0] = '0; e_loc[1] = '0;
  end

  task automatic model_finish();
    for (int c = 0; c < 2; c++) begin
      e_synd[c] = '0;
      e_loc[c]  = '0;
      for (int j = 0; j < m_chk; j++) begin
        logic [7:0] s = 8'h00;
        for (int i = 0; i < m_len; i++)
          if (m_syms[i] != 0)
            s ^= exp_t[c][(log_t[c][m_syms[i]] + ((c ? 120 : 0) + j) * (m_len - 1 - i)) % 255];
        e_synd[c][j*8 +: 8] = s;
      end
      for (int k = 0; k < m_eras.size() && k < m_chk; k++)
        e_loc[c][k*8 +: 8] = exp_t[c][m_len - 1 - m_eras[k]];
    end
    e_cnt = CHK_W'((m_eras.size() < m_chk) ? m_eras.size() : m_chk);
    e_ovf = m_eras.size() > m_chk;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act = 0; e_done = 0; e_cnt = '0; e_ovf = 0;
      e_synd[0] = '0; e_synd[1] = '0; e_loc[0] = '0; e_loc[1] = '0;
    end else begin
      e_done = 0;
      if (vld) begin
        if (fs) begin
          m_act = 1; m_len = cfg_len; m_chk = (cfg_chk > MAX_CHK) ? MAX_CHK : cfg_chk;
          m_syms.delete(); m_eras.delete();
        end
        if (m_act) begin
          m_syms.push_back(sym);
          if (era) m_eras.push_back(m_syms.size() - 1);
          if (m_syms.size() == m_len) begin
            model_finish();
            m_act = 0; e_done = 1;
          end
        end
      end
    end
  end

  task automatic cmp(string name, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      cmp("done_a", W'(done_a), W'(e_done));
      cmp("done_b", W'(done_b), W'(e_done));
      cmp("synd_a", synd_a, e_synd[0]);
      cmp("synd_b", synd_b, e_synd[1]);
      cmp("loc_a", loc_a, e_loc[0]);
      cmp("loc_b", loc_b, e_loc[1]);
      cmp("cnt_a", W'(cnt_a), W'(e_cnt));
      cmp("cnt_b", W'(cnt_b), W'(e_cnt));
      cmp("ovf_a", W'(ovf_a), W'(e_ovf));
      cmp("ovf_b", W'(ovf_b), W'(e_ovf));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // stimulus helpers
  logic [7:0] tx[$];
  bit         tx_era[$];

  task automatic drive(logic v, logic f, logic e, logic [7:0] d);
    vld = v; fs = f; era = e; sym = d;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'($urandom), 1'($urandom), 8'($urandom));
  endtask

  task automatic build(int c, int n, int chk, int nerr, int nera);
    logic [7:0] g [0:20];
    logic [7:0] rem [0:20];
    logic [7:0] fb;
    tx.delete(); tx_era.delete();
    for (int i = 0; i <= 20; i++) begin g[i] = 0; rem[i] = 0; end
    g[0] = 8'h01;
    for (int j = 0; j < chk; j++) begin
      logic [7:0] r = exp_t[c][((c ? 120 : 0) + j) % 255];
      for (int i = j + 1; i >= 1; i--) g[i] = g[i-1] ^ bm(c, g[i], r);
      g[0] = bm(c, g[0], r);
    end
    for (int i = 0; i < n - chk; i++) begin
      logic [7:0] d = 8'($urandom);
      tx.push_back(d); tx_era.push_back(1'b0);
      if (chk > 0) begin
        fb = d ^ rem[chk-1];
        for (int k = chk - 1; k >= 1; k--) rem[k] = rem[k-1] ^ bm(c, fb, g[k]);
        rem[0] = bm(c, fb, g[0]);
      end
    end
    for (int k = chk - 1; k >= 0; k--) begin tx.push_back(rem[k]); tx_era.push_back(1'b0); end
    for (int k = 0; k < nerr; k++) tx[(k * 37 + 5) % n] ^= 8'(k + 1);
    for (int k = 0; k < nera; k++) tx_era[(k * 53 + 11) % n] = 1'b1;
  endtask

  task automatic play(int mid_len, bit gaps);
    for (int i = 0; i < tx.size(); i++) begin
      drive(1'b1, i == 0, tx_era[i], tx[i]);
      if (i == 0 && mid_len > 0) cfg_len = 8'(mid_len);
      if (gaps && (i % 7) == 3) idle(2);
    end
    vld = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      int x = 1;
      for (int e = 0; e < 255; e++) begin
        exp_t[c][e] = 8'(x);
        log_t[c][x] = e;
        x = x << 1;
        if (x & 256) x = (x ^ (c ? 'h187 : 'h11D)) & 255;
      end
      log_t[c][0] = 0;
    end
    idle(3);
    rst_ni = 1'b1;
    // R11 reset state
    req = "R11";
    idle(2);
    cmp("reset synd_a", synd_a, '0);
    cmp("reset loc_b", loc_b, '0);

    // R10 / R2 error-free word, convention A
    req = "R10"; cfg_len = 8'd255; cfg_chk = 5'd16;
    build(0, 255, 16, 0, 0); play(0, 0); idle(3);
    cmp("R10 clean synd_a zero", synd_a, '0);

    // R3 / R10 error-free word, convention B
    req = "R3"; cfg_len = 8'd204; cfg_chk = 5'd16;
    build(1, 204, 16, 0, 0); play(0, 0); idle(3);
    cmp("R3 clean synd_b zero", synd_b, '0);
    build(1, 204, 16, 3, 0); play(0, 0); idle(3);

    // R2 / R8 errors and erasures
    req = "R2"; cfg_len = 8'd100; cfg_chk = 5'd20;
    build(0, 100, 20, 5, 3); play(0, 0); idle(3);
    req = "R8";
    build(1, 120, 10, 0, 4); cfg_len = 8'd120; cfg_chk = 5'd10; play(0, 0); idle(2);

    // R5 check count 0 and small
    req = "R5"; cfg_len = 8'd50; cfg_chk = 5'd0;
    build(0, 50, 0, 2, 1); play(0, 0); idle(3);
    cfg_len = 8'd60; cfg_chk = 5'd5;
    build(0, 60, 5, 1, 0); play(0, 0); idle(3);

    // R6 gaps with junk, stray valid symbols outside a frame
    req = "R6"; cfg_len = 8'd90; cfg_chk = 5'd10;
    build(0, 90, 10, 2, 2); play(0, 1);
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 1'($urandom), 8'($urandom));
    idle(3);

    // R7 aborted frame
    req = "R7"; cfg_len = 8'd80; cfg_chk = 5'd8;
    build(1, 80, 8, 1, 2);
    for (int i = 0; i < 30; i++) drive(1'b1, i == 0, tx_era[i], tx[i]);
    build(1, 80, 8, 0, 0); play(0, 0); idle(3);
    cmp("R7 restarted clean synd_b zero", synd_b, '0);

    // R9 erasure overflow
    req = "R9"; cfg_len = 8'd70; cfg_chk = 5'd4;
    build(0, 70, 4, 0, 7); play(0, 0); idle(3);
    cmp("R9 ovf_a", W'(ovf_a), W'(1));

    // R4 back-to-back short words
    req = "R4"; cfg_len = 8'd50; cfg_chk = 5'd4;
    for (int f = 0; f < 3; f++) begin build(f % 2, 50, 4, f, 1); play(0, 0); end
    idle(3);

    // R1 configuration change mid-frame ignored
    req = "R1"; cfg_len = 8'd150; cfg_chk = 5'd12;
    build(0, 150, 12, 0, 0); play(60, 0); idle(3);
    cmp("R1 clean synd_a zero", synd_a, '0);
    idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule